// File: doc/BRIEF.md
# SPI Burst Slave with Transmit and Receive FIFOs

This block is the host-facing serial front end of a radio-style peripheral. A host drives a mode-0 SPI link (clock idle low, data MSB first) and, inside a single chip-select-low window, sends a chain of operations. The first byte of each operation is a header. Its bit 6 selects read (1) or write (0), and bits 5:0 select an address. Low addresses are single-byte command strobes. The middle range holds 16-bit control registers, each moved as two bytes. The top two addresses open a burst to one of two 128-byte FIFOs.

A FIFO burst has no length field. Once the FIFO header is taken, every later byte in the window is FIFO data, even if its value looks like a header. The burst ends only when chip select rises. Whenever the host is writing, the slave returns a status byte on the serial output. This lets the host see transmit underflow and overflow while it streams data. The radio side drains the transmit FIFO and fills the receive FIFO through a simple pop/push port. Two strobes empty one FIFO each.

All serial pins are brought into the system clock domain through a synchronizer. SCLK must therefore be slow compared with `clk`.

Top module: `spi_burst_slave`

## Requirements
- R1: SPI mode 0, MSB first. SI is taken on rising SCLK and SO moves after falling SCLK. `so_oe` is 1 only while CSn is low, and SO shows a fresh byte from the first bit of each byte.
- R2: A header byte's bit 6 is read, its bits 5:0 are the address, and the slave returns the status byte on SO during every header. Addresses 0x00–0x0F are strobes, and strobes other than 0x08 and 0x09 change nothing.
- R3: Addresses 0x10–0x3D are 16-bit registers (reset 0x0000) moved as two bytes, high byte first. A write takes effect after its second byte. Strobes, register accesses and a FIFO burst may be chained in one CSn-low window.
- R4: Header 0x3E starts a transmit-FIFO write burst of any length. The radio side sees the bytes in the order written on `tx_pop_data`, and `tx_level` counts them.
- R5: After a FIFO header, every byte until CSn rises is FIFO data, whatever its value.
- R6: While the host writes, SO carries the status byte for each data byte. Status bits: 0 transmit underflow, 1 transmit overflow, 2 receive underflow, 3 transmit FIFO empty, 4 receive FIFO empty, 7:5 zero.
- R7: A transmit-FIFO write while the FIFO holds 128 bytes is dropped and sets status bit 1.
- R8: A radio-side pop of an empty transmit FIFO sets status bit 0.
- R9: Header 0x7F (read, 0x3F) returns receive-FIFO bytes in arrival order, one per following byte. A byte shown while the FIFO is empty reads 0x00 and, once that byte completes, sets status bit 2 and removes nothing.
- R10: Header 0x3F (write) pushes host bytes into the receive FIFO. Header 0x7E (read of the transmit FIFO) leaves the transmit FIFO unchanged and returns status.
- R11: Strobe 0x09 empties the transmit FIFO and clears status bits 0 and 1. Strobe 0x08 empties the receive FIFO and clears status bit 2.
- R12: CSn rising discards a partly shifted byte and any unfinished operation. The next window starts with a header.
- R13: After reset both FIFOs are empty, all flags are clear and `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| csn | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |
| tx_pop | input | 1 | Radio side removes the transmit FIFO head |
| tx_pop_data | output | 8 | Transmit FIFO head byte |
| tx_level | output | $clog2(FIFO_DEPTH)+1 | Bytes held in the transmit FIFO |
| rx_push | input | 1 | Radio side stores `rx_push_data` |
| rx_push_data | input | 8 | Byte from the radio side |
| rx_level | output | $clog2(FIFO_DEPTH)+1 | Bytes held in the receive FIFO |

## Verification
The assertions assume SCLK is slow enough that each SCLK phase covers at least three `clk` cycles after synchronization. They also assume SI is steady around each rising SCLK edge. The bench meets this with four-`clk` half periods and by changing SI only at falling edges. A radio-side push that lands in the same cycle as a host write to the receive FIFO wins and drops the host byte, so the bench moves the radio-side ports only while CSn is high. The reference model updates its queues and flags once per completed byte, so it is compared against the FIFO levels on every clock of the idle gaps between windows.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  localparam logic [5:0] A_FLUSH_RX   = 6'h08;
  localparam logic [5:0] A_FLUSH_TX   = 6'h09;
  localparam logic [5:0] A_STROBE_TOP = 6'h0F;
  localparam logic [5:0] A_REG_FIRST  = 6'h10;
  localparam logic [5:0] A_REG_LAST   = 6'h3D;
  localparam logic [5:0] A_TX_FIFO    = 6'h3E;
  localparam int         HDR_RD_BIT   = 6;

  typedef enum logic [2:0] {
    PS_HDR,
    PS_REG_HI,
    PS_REG_LO,
    PS_TX_WR,
    PS_TX_RD,
    PS_RX_WR,
    PS_RX_RD
  } parse_t;

  function automatic logic [7:0] pack_status(input logic tx_unf, input logic tx_ovf,
                                             input logic rx_unf, input logic tx_emp,
                                             input logic rx_emp);
    return {3'b000, rx_emp, tx_emp, rx_unf, tx_ovf, tx_unf};
  endfunction

  function automatic parse_t hdr_next(input logic [7:0] hdr);
    logic [5:0] a;
    a = hdr[5:0];
    if (a <= A_STROBE_TOP)    return PS_HDR;
    else if (a <= A_REG_LAST) return PS_REG_HI;
    else if (a == A_TX_FIFO)  return hdr[HDR_RD_BIT] ? PS_TX_RD : PS_TX_WR;
    else                      return hdr[HDR_RD_BIT] ? PS_RX_RD : PS_RX_WR;
  endfunction

  function automatic logic is_burst(input parse_t s);
    return (s == PS_TX_WR) || (s == PS_TX_RD) || (s == PS_RX_WR) || (s == PS_RX_RD);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 128,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [AW:0]   level,
  output logic          full,
  output logic          empty
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (level == FULL_CNT);
  assign empty   = (level == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      level <= level + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
  parameter int         NREG = 46,
  parameter int         RW   = 16,
  parameter logic [5:0] BASE = 6'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [5:0]    waddr,
  input  logic [RW-1:0] wdata,
  input  logic [5:0]    raddr,
  output logic [RW-1:0] rdata
);
  logic [RW-1:0] regs [NREG];
  logic [5:0]    widx, ridx;

  assign widx  = waddr - BASE;
  assign ridx  = raddr - BASE;
  assign rdata = (int'(ridx) < NREG) ? regs[ridx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && int'(widx) < NREG) begin
      regs[widx] <= wdata;
    end
  end
endmodule

// File: rtl/spi_burst_slave.sv
module spi_burst_slave
  import spi_burst_pkg::*;
#(
  parameter int  FIFO_DEPTH  = 128,
  parameter int  REG_COUNT   = 46,
  parameter int  SYNC_STAGES = 2,
  localparam int LW          = $clog2(FIFO_DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          csn,
  input  logic          si,
  output logic          so,
  output logic          so_oe,
  input  logic          tx_pop,
  output logic [7:0]    tx_pop_data,
  output logic [LW-1:0] tx_level,
  input  logic          rx_push,
  input  logic [7:0]    rx_push_data,
  output logic [LW-1:0] rx_level
);
  // pin synchronization and edge events
  logic [2:0] pins_s;
  logic       sclk_s, csn_s, si_s, sclk_d, csn_d;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk), .rst_n (rst_n), .d ({sclk, csn, si}), .q (pins_s)
  );
  assign {sclk_s, csn_s, si_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  logic sclk_rise, sclk_fall, csn_fall;
  assign sclk_rise = sclk_s && !sclk_d && !csn_s;
  assign sclk_fall = !sclk_s && sclk_d && !csn_s;
  assign csn_fall  = !csn_s && csn_d;

  // input byte assembly
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic       byte_done;
  logic [7:0] in_byte;

  assign byte_done = sclk_rise && (bitcnt == 3'd7);
  assign in_byte   = {rx_sh, si_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0;
      rx_sh  <= '0;
    end else if (csn_s) begin
      bitcnt <= '0;
      rx_sh  <= '0;
    end else if (sclk_rise) begin
      bitcnt <= bitcnt + 3'd1;
      rx_sh  <= in_byte[6:0];
    end
  end

  // parser
  parse_t     st;
  logic       hdr_rd;
  logic [5:0] hdr_addr;
  logic [7:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PS_HDR;
      hdr_rd   <= 1'b0;
      hdr_addr <= '0;
      hi_q     <= '0;
    end else if (csn_s) begin
      st <= PS_HDR;
    end else if (byte_done) begin
      case (st)
        PS_HDR: begin
          st       <= hdr_next(in_byte);
          hdr_rd   <= in_byte[HDR_RD_BIT];
          hdr_addr <= in_byte[5:0];
        end
        PS_REG_HI: begin
          hi_q <= in_byte;
          st   <= PS_REG_LO;
        end
        PS_REG_LO: st <= PS_HDR;
        default:   st <= st;
      endcase
    end
  end

  // named operation events
  logic strobe_ev, flush_tx_ev, flush_rx_ev, reg_wr_ev;
  logic tx_wr_req, rx_wr_req, rx_rd_req;

  assign strobe_ev   = byte_done && (st == PS_HDR) && (in_byte[5:0] <= A_STROBE_TOP);
  assign flush_tx_ev = strobe_ev && (in_byte[5:0] == A_FLUSH_TX);
  assign flush_rx_ev = strobe_ev && (in_byte[5:0] == A_FLUSH_RX);
  assign reg_wr_ev   = byte_done && (st == PS_REG_LO) && !hdr_rd;
  assign tx_wr_req   = byte_done && (st == PS_TX_WR);
  assign rx_wr_req   = byte_done && (st == PS_RX_WR) && !rx_push;
  assign rx_rd_req   = byte_done && (st == PS_RX_RD);

  // registers
  logic [15:0] reg_rdata;

  spi_reg_bank #(.NREG(REG_COUNT), .RW(16), .BASE(A_REG_FIRST)) u_regs (
    .clk (clk), .rst_n (rst_n), .we (reg_wr_ev), .waddr (hdr_addr),
    .wdata ({hi_q, in_byte}), .raddr (hdr_addr), .rdata (reg_rdata)
  );

  // FIFOs
  logic       tx_full, tx_empty, rx_full, rx_empty, load_empty, rx_pop_ev;
  logic [7:0] rx_head;

  assign rx_pop_ev = rx_rd_req && !load_empty;

  byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk (clk), .rst_n (rst_n), .flush (flush_tx_ev),
    .push (tx_wr_req), .push_data (in_byte), .pop (tx_pop),
    .head (tx_pop_data), .level (tx_level), .full (tx_full), .empty (tx_empty)
  );

  byte_fifo #(.DW(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk (clk), .rst_n (rst_n), .flush (flush_rx_ev),
    .push (rx_push || rx_wr_req), .push_data (rx_push ? rx_push_data : in_byte),
    .pop (rx_pop_ev), .head (rx_head), .level (rx_level),
    .full (rx_full), .empty (rx_empty)
  );

  // status flags
  logic       tx_unf, tx_ovf, rx_unf;
  logic [7:0] status;

  assign status = pack_status(tx_unf, tx_ovf, rx_unf, tx_empty, rx_empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_unf <= 1'b0;
      tx_ovf <= 1'b0;
      rx_unf <= 1'b0;
    end else begin
      if (flush_tx_ev) begin
        tx_unf <= 1'b0;
        tx_ovf <= 1'b0;
      end else begin
        if (tx_pop && tx_empty)   tx_unf <= 1'b1;
        if (tx_wr_req && tx_full) tx_ovf <= 1'b1;
      end
      if (flush_rx_ev)                  rx_unf <= 1'b0;
      else if (rx_rd_req && load_empty) rx_unf <= 1'b1;
    end
  end

  // output byte selection and shifting
  logic [7:0] next_out, sh_o;

  always_comb begin
    case (st)
      PS_REG_HI: next_out = hdr_rd ? reg_rdata[15:8] : status;
      PS_REG_LO: next_out = hdr_rd ? reg_rdata[7:0]  : status;
      PS_RX_RD:  next_out = rx_empty ? 8'h00 : rx_head;
      default:   next_out = status;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_o       <= '0;
      load_empty <= 1'b0;
    end else if (csn_s) begin
      sh_o       <= '0;
      load_empty <= 1'b0;
    end else if (csn_fall) begin
      sh_o       <= status;
      load_empty <= 1'b0;
    end else if (sclk_fall) begin
      if (bitcnt == 3'd0) begin
        sh_o       <= next_out;
        load_empty <= (st == PS_RX_RD) && rx_empty;
      end else begin
        sh_o <= {sh_o[6:0], 1'b0};
      end
    end
  end

  assign so    = sh_o[7];
  assign so_oe = !csn_s;

endmodule

// File: rtl/spi_burst_slave_chk.sv
module spi_burst_slave_chk
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LW    = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          csn_s,
  input parse_t        st,
  input logic [2:0]    bitcnt,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_wr_req,
  input logic          tx_full,
  input logic          tx_pop,
  input logic          rx_rd_req,
  input logic          load_empty,
  input logic          flush_tx_ev,
  input logic          flush_rx_ev,
  input logic [7:0]    status
);
  AST_TX_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_level) <= DEPTH);  // R7
  AST_OVF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_wr_req && tx_full && !tx_pop) |=> (tx_full && status[1]));  // R7
  AST_TX_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_level == '0 && !flush_tx_ev) |=> status[0]);  // R8
  AST_RX_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd_req && load_empty && !flush_rx_ev) |=> status[2]);  // R9
  AST_FLUSH_TX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx_ev |=> (tx_level == '0 && !status[0] && !status[1]));  // R11
  AST_FLUSH_RX: assert property (@(posedge clk) disable iff (!rst_n)
    flush_rx_ev |=> (rx_level == '0 && !status[2]));  // R11
  AST_CS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (st == PS_HDR && bitcnt == 3'd0));  // R12
  AST_BURST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_s && is_burst(st)) |=> (st == $past(st)));  // R5
endmodule

bind spi_burst_slave spi_burst_slave_chk #(.DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
  .clk (clk), .rst_n (rst_n), .csn_s (csn_s), .st (st), .bitcnt (bitcnt),
  .tx_level (tx_level), .rx_level (rx_level), .tx_wr_req (tx_wr_req),
  .tx_full (tx_full), .tx_pop (tx_pop), .rx_rd_req (rx_rd_req),
  .load_empty (load_empty), .flush_tx_ev (flush_tx_ev),
  .flush_rx_ev (flush_rx_ev), .status (status)
);

// File: tb/test_spi_burst_slave.sv
module test_spi_burst_slave;
  logic       clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, si = 1'b0;
  logic       tx_pop = 1'b0, rx_push = 1'b0;
  logic [7:0] rx_push_data = '0;
  logic       so, so_oe;
  logic [7:0] tx_pop_data, tx_level, rx_level;

  spi_burst_slave i_spi_burst_slave (
    .clk (clk), .rst_n (rst_n), .sclk (sclk), .csn (csn), .si (si),
    .so (so), .so_oe (so_oe), .tx_pop (tx_pop), .tx_pop_data (tx_pop_data),
    .tx_level (tx_level), .rx_push (rx_push), .rx_push_data (rx_push_data),
    .rx_level (rx_level)
  );

  always #5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [7:0]  txq[$], rxq[$];
  bit          m_tunf = 0, m_tovf = 0, m_runf = 0;
  logic [15:0] mreg [64];

  function automatic logic [7:0] m_stat();
    return {3'b000, rxq.size() == 0, txq.size() == 0, m_runf, m_tovf, m_tunf};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int nb, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i > 7 - nb; i--) begin
      si = mo[i];
      repeat (4) @(negedge clk);
      sclk  = 1'b1;
      mi[i] = so;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xb(input logic [7:0] mo, input logic [7:0] exp, input string req);
    logic [7:0] mi;
    spi_bits(mo, 8, mi);
    check(req, {8'h00, mi}, {8'h00, exp});
  endtask

  task automatic cs_lo();
    @(negedge clk);
    csn = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // per-clock comparison of levels during an idle gap
  task automatic idle_cmp(input string req);
    bit bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (int'(tx_level) != txq.size() || int'(rx_level) != rxq.size()) bad = 1;
    end
    n_run++;
    if (bad) begin
      n_fail++;
      $display("FAIL %s levels act=%0d/%0d exp=%0d/%0d", req, tx_level, rx_level,
               txq.size(), rxq.size());
    end
  endtask

  task automatic radio_push(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1;
    rx_push_data = b;
    @(negedge clk);
    rx_push = 1'b0;
    rxq.push_back(b);
  endtask

  task automatic radio_pop(input string req);
    @(negedge clk);
    if (txq.size() > 0) begin
      check(req, {8'h00, tx_pop_data}, {8'h00, txq[0]});
      void'(txq.pop_front());
    end else begin
      m_tunf = 1;
    end
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] mi;
    for (int i = 0; i < 64; i++) mreg[i] = '0;
    repeat (5) @(negedge clk);
    check("R13", {15'h0, so_oe}, 16'h0);
    check("R13", {tx_level, rx_level}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: register write then read in one window
    cs_lo();
    check("R1", {15'h0, so_oe}, 16'h1);
    xb(8'h12, m_stat(), "R2");
    xb(8'hA5, m_stat(), "R6");
    xb(8'h5A, m_stat(), "R6");
    mreg[6'h12] = 16'hA55A;
    xb(8'h52, m_stat(), "R3");
    xb(8'h00, mreg[6'h12][15:8], "R3");
    xb(8'h00, mreg[6'h12][7:0], "R3");
    cs_hi();
    check("R1", {15'h0, so_oe}, 16'h0);

    // R3/R4: strobe, register write and TX burst chained
    cs_lo();
    xb(8'h09, m_stat(), "R2");
    txq.delete(); m_tunf = 0; m_tovf = 0;
    xb(8'h13, m_stat(), "R3");
    xb(8'h12, m_stat(), "R3");
    xb(8'h34, m_stat(), "R3");
    mreg[6'h13] = 16'h1234;
    xb(8'h3E, m_stat(), "R4");
    for (int i = 0; i < 3; i++) begin
      xb(8'hB0 + 8'(i), m_stat(), "R6");
      txq.push_back(8'hB0 + 8'(i));
    end
    cs_hi();
    idle_cmp("R4");

    // R5: header-looking bytes inside a burst are data
    cs_lo();
    xb(8'h3E, m_stat(), "R5");
    xb(8'h09, m_stat(), "R5"); txq.push_back(8'h09);
    xb(8'h53, m_stat(), "R5"); txq.push_back(8'h53);
    cs_hi();
    idle_cmp("R5");
    cs_lo();
    xb(8'h53, m_stat(), "R5");
    xb(8'h00, 8'h12, "R5");
    xb(8'h00, 8'h34, "R5");
    cs_hi();

    // R4: radio drains in write order; R8: pop on empty
    while (txq.size() > 0) radio_pop("R4");
    radio_pop("R8");
    cs_lo();
    xb(8'h00, m_stat(), "R8");
    cs_hi();

    // R7: overflow after 128 bytes
    cs_lo();
    xb(8'h3E, m_stat(), "R7");
    for (int i = 0; i < 130; i++) begin
      xb(8'(i), m_stat(), "R7");
      if (txq.size() < 128) txq.push_back(8'(i));
      else m_tovf = 1;
    end
    check("R7", {8'h00, m_stat()}, 16'h0013);
    cs_hi();
    idle_cmp("R7");

    // R10: read of the TX FIFO address changes nothing
    cs_lo();
    xb(8'h7E, m_stat(), "R10");
    xb(8'h11, m_stat(), "R10");
    cs_hi();
    idle_cmp("R10");

    // R11: flush TX clears level and both TX flags
    cs_lo();
    xb(8'h09, m_stat(), "R11");
    txq.delete(); m_tunf = 0; m_tovf = 0;
    xb(8'h00, m_stat(), "R11");
    cs_hi();
    idle_cmp("R11");

    // R9: RX read in order, then empty gives 0x00 and flag
    radio_push(8'hC1); radio_push(8'hC2); radio_push(8'hC3);
    idle_cmp("R9");
    cs_lo();
    xb(8'h7F, m_stat(), "R9");
    for (int i = 0; i < 4; i++) begin
      xb(8'hFF, (rxq.size() > 0) ? rxq[0] : 8'h00, "R9");
      if (rxq.size() > 0) void'(rxq.pop_front());
      else m_runf = 1;
    end
    cs_hi();
    idle_cmp("R9");
    cs_lo();
    xb(8'h00, m_stat(), "R9");
    cs_hi();

    // R10: host writes into RX FIFO and reads back
    cs_lo();
    xb(8'h3F, m_stat(), "R10");
    xb(8'hD1, m_stat(), "R10"); rxq.push_back(8'hD1);
    xb(8'hD2, m_stat(), "R10"); rxq.push_back(8'hD2);
    cs_hi();
    idle_cmp("R10");
    cs_lo();
    xb(8'h7F, m_stat(), "R10");
    xb(8'h00, 8'hD1, "R10"); void'(rxq.pop_front());
    cs_hi();
    idle_cmp("R10");

    // R11: flush RX clears level and RX flag
    radio_push(8'hE7);
    cs_lo();
    xb(8'h08, m_stat(), "R11");
    rxq.delete(); m_runf = 0;
    xb(8'h00, m_stat(), "R11");
    cs_hi();
    idle_cmp("R11");

    // R12: partial byte discarded on CSn rise
    cs_lo();
    spi_bits(8'h3E, 4, mi);
    cs_hi();
    cs_lo();
    xb(8'h14, m_stat(), "R12");
    xb(8'hAB, m_stat(), "R12");
    xb(8'hCD, m_stat(), "R12");
    mreg[6'h14] = 16'hABCD;
    xb(8'h54, m_stat(), "R12");
    xb(8'h00, 8'hAB, "R12");
    xb(8'h00, 8'hCD, "R12");
    cs_hi();
    idle_cmp("R12");

    // R2: unused strobe changes nothing
    cs_lo();
    xb(8'h03, m_stat(), "R2");
    xb(8'h00, m_stat(), "R2");
    cs_hi();
    idle_cmp("R2");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule